// File: doc/BRIEF.md
# Self-Recovering Modified One-Hot Sequencer

This block is a free-running cyclic sequencer for an n-state control loop, kept in n-1 flip-flops. The home state is the all-zero vector; every other state has exactly one bit set. Each advance shifts the state vector one place toward its most significant bit. When the vector is all zero, a NOR of every bit supplies the 1 that enters bit 0. The bit leaving the top stage is dropped, so the state after the last one-hot state is home. Because of this, the ring restarts itself from home without any reset.

The same structure lets the ring recover from corrupted state. If a transient clears the single set bit, the ring lands in home, which is a legal state, and carries on from there. If a transient leaves two or more bits set, the NOR feeds nothing in and no correction is applied. The extra ones drain out of the top stage, and the ring regains a legal code within n-2 advances.

A flag reports such a multi-hot vector, and a home indicator pulses once per lap. The sequencer moves only when its advance enable is high. An upset-injection input XORs a pattern into the state at the next clock edge, so the recovery path can be exercised. The asynchronous active-low reset clears the state immediately and is released through a synchronizer.

Top module: `mohs_seq`

## Requirements
- R1: While `rst_ni` is low the state is all zero, and it clears without waiting for a clock edge. After `rst_ni` rises, the first two rising clock edges still leave the state at zero (two-stage synchronized release); the third edge is the first that can advance it.
- R2: From home (all zero), an advancing edge with no upset gives state 1 (bit 0 set).
- R3: From a one-hot state with bit i set, i < NUM_STATES-2, an advancing edge with no upset gives bit i+1 alone set.
- R4: From the state with only the top bit (bit NUM_STATES-2) set, an advancing edge with no upset returns the state to all zero. The ring order is therefore 0, 1, 2, 4, 0 for four states.
- R5: With `advance_i` low and `upset_i` zero, the state holds.
- R6: `home_o` is 1 exactly when every state bit is 0.
- R7: `multi_hot_o` is 1 exactly when two or more state bits are 1.
- R8: From a state with two or more bits set, an advancing edge shifts every bit up one place, drops the top bit and enters 0 in bit 0. A legal code (zero or one-hot) is reached within NUM_STATES-2 advances.
- R9: `upset_i` is XORed bitwise into the state at the next rising edge. This happens after the advance step, and also when `advance_i` is low.
- R10: An upset that clears the only set bit yields home with `multi_hot_o` low. The ring then resumes from home, reaching state 1 on the next advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset, synchronously released |
| advance_i | input | 1 | Clock enable: step the ring on this edge |
| upset_i | input | NUM_STATES-1 | Fault-injection pattern XORed into the state |
| state_o | output | NUM_STATES-1 | Current state vector (zero = home) |
| home_o | output | 1 | High in the home state |
| multi_hot_o | output | 1 | High when two or more state bits are set |

## Verification
The bench walks several full laps and checks the wrap from the top bit back to zero. A design that fed the top bit around, as a plain one-hot ring does, would jump to state 1 and never show home. It then injects multi-hot patterns and checks the drain order cycle by cycle. A NOR that was wrongly replaced by an OR-reduce, or a feed term left active while bits were set, would keep ones in circulation forever and the flag would never fall. It also clears the single set bit to check that the ring restarts from home, holds with the enable low, and asserts reset between edges to catch a reset that is really synchronous, or a release that skips the synchronizer stages.

// File: rtl/mohs_pkg.sv
package mohs_pkg;

  // Status flags decoded from the state vector.
  typedef struct packed {
    logic home;
    logic multi;
  } seq_flags_t;

  localparam int unsigned DEFAULT_STATES      = 4;
  localparam int unsigned DEFAULT_SYNC_STAGES = 2;

endpackage

// File: rtl/mohs_reset_sync.sv
// Asynchronous assert, synchronous release of an active-low reset.
module mohs_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/mohs_next_state.sv
// Shift-up with NOR feed into bit 0; the top bit falls off the end.
module mohs_next_state #(
  parameter int unsigned WIDTH = 3
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic             advance_i,
  input  logic [WIDTH-1:0] upset_i,
  output logic [WIDTH-1:0] next_o,
  output logic             load_o
);

  logic             feed;
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] stepped;

  assign feed = ~|state_i;

  generate
    if (WIDTH == 1) begin : g_single
      assign shifted = feed;
    end else begin : g_chain
      assign shifted = {state_i[WIDTH-2:0], feed};
    end
  endgenerate

  always_comb begin
    stepped = advance_i ? shifted : state_i;
    next_o  = stepped ^ upset_i;
    load_o  = advance_i | (|upset_i);
  end

endmodule

// File: rtl/mohs_state_reg.sv
// State flip-flops with explicit clock enable and async clear to home.
module mohs_state_reg #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (en_i) begin
      q <= d_i;
    end
  end

  assign q_o = q;

endmodule

// File: rtl/mohs_monitor.sv
// Decodes home and the illegal multi-hot condition.
module mohs_monitor #(
  parameter int unsigned WIDTH = 3
) (
  input  logic [WIDTH-1:0]        state_i,
  output mohs_pkg::seq_flags_t    flags_o
);

  logic [WIDTH-1:0] low_cleared;

  always_comb begin
    // Clearing the lowest set bit leaves something only if 2+ bits were set.
    low_cleared   = state_i & (state_i - WIDTH'(1));
    flags_o.home  = ~|state_i;
    flags_o.multi = |low_cleared;
  end

endmodule

// File: rtl/mohs_seq.sv
// Self-recovering modified one-hot sequencer (top level).
module mohs_seq #(
  parameter int unsigned NUM_STATES  = mohs_pkg::DEFAULT_STATES,
  parameter int unsigned SYNC_STAGES = mohs_pkg::DEFAULT_SYNC_STAGES,
  localparam int unsigned WIDTH      = NUM_STATES - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  input  logic [WIDTH-1:0] upset_i,
  output logic [WIDTH-1:0] state_o,
  output logic             home_o,
  output logic             multi_hot_o
);

  logic                 rst_n_sync;
  logic [WIDTH-1:0]     state_q;
  logic [WIDTH-1:0]     state_d;
  logic                 load;
  mohs_pkg::seq_flags_t flags;

  mohs_reset_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  mohs_next_state #(.WIDTH(WIDTH)) u_next (
    .state_i   (state_q),
    .advance_i (advance_i),
    .upset_i   (upset_i),
    .next_o    (state_d),
    .load_o    (load)
  );

  mohs_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .en_i   (load),
    .d_i    (state_d),
    .q_o    (state_q)
  );

  mohs_monitor #(.WIDTH(WIDTH)) u_mon (
    .state_i (state_q),
    .flags_o (flags)
  );

  assign state_o     = state_q;
  assign home_o      = flags.home;
  assign multi_hot_o = flags.multi;

endmodule

// File: rtl/mohs_seq_checker.sv
module mohs_seq_checker #(
  parameter int unsigned WIDTH = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             advance_i,
  input logic [WIDTH-1:0] upset_i,
  input logic [WIDTH-1:0] state_o,
  input logic             home_o,
  input logic             multi_hot_o
);

  localparam int unsigned CW = $clog2(WIDTH + 1) + 1;

  logic [CW-1:0] drain_cnt;
  logic          quiet;

  assign quiet = (upset_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drain_cnt <= '0;
    end else if (!multi_hot_o || !quiet) begin
      drain_cnt <= '0;
    end else if (advance_i) begin
      drain_cnt <= drain_cnt + CW'(1);
    end
  end

  p_home_to_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == '0 && advance_i && quiet) |=> (state_o == WIDTH'(1)));

  p_shift_up_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(state_o) == 1 && !state_o[WIDTH-1] && advance_i && quiet)
      |=> (state_o == ($past(state_o) << 1)));

  p_wrap_home_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(state_o) == 1 && state_o[WIDTH-1] && advance_i && quiet)
      |=> (state_o == '0));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!advance_i && quiet) |=> $stable(state_o));

  p_home_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    home_o == ($countones(state_o) == 0));

  p_multi_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_hot_o == ($countones(state_o) > 1));

  p_no_growth_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (multi_hot_o && advance_i && quiet)
      |=> ($countones(state_o) <= $past($countones(state_o))));

  p_drain_window_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_hot_o |-> (drain_cnt < CW'(WIDTH - 1)));

  p_upset_xor_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!advance_i && !quiet) |=> (state_o == ($past(state_o) ^ $past(upset_i))));

endmodule

bind mohs_seq mohs_seq_checker #(.WIDTH(WIDTH)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_n_sync),
  .advance_i   (advance_i),
  .upset_i     (upset_i),
  .state_o     (state_o),
  .home_o      (home_o),
  .multi_hot_o (multi_hot_o)
);

// File: tb/mohs_seq_tb_top.sv
module mohs_seq_tb_top;

  localparam int unsigned N = 4;
  localparam int unsigned W = N - 1;

  logic         clk_i;
  logic         rst_ni;
  logic         advance_i;
  logic [W-1:0] upset_i;
  logic [W-1:0] state_o;
  logic         home_o;
  logic         multi_hot_o;

  int unsigned vectors;
  int unsigned miscompares;
  int unsigned frozen_left;
  logic [W-1:0] model;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  mohs_seq #(.NUM_STATES(N)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .advance_i   (advance_i),
    .upset_i     (upset_i),
    .state_o     (state_o),
    .home_o      (home_o),
    .multi_hot_o (multi_hot_o)
  );

  initial clk_i = 1'b0;
  always #4 clk_i = ~clk_i;  // 125 MHz

  task automatic compare(input logic [W-1:0] exp_s, input string tag);
    logic exp_home;
    logic exp_multi;
    exp_home  = (exp_s == '0);
    exp_multi = ($countones(exp_s) >= 2);
    vectors++;
    if (state_o !== exp_s) begin
      miscompares++;
      $display("FAIL %s state: actual %b expected %b", tag, state_o, exp_s);
    end else if (home_o !== exp_home) begin
      miscompares++;
      $display("FAIL R6 home_o: actual %b expected %b", home_o, exp_home);
    end else if (multi_hot_o !== exp_multi) begin
      miscompares++;
      $display("FAIL R7 multi_hot_o: actual %b expected %b", multi_hot_o, exp_multi);
    end
  endtask

  // Monitor: one expected item per rising edge, sampled after it settles.
  always begin
    @(posedge clk_i);
    #2;
    if (exp_q.size() > 0) begin
      compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  // Driver: set inputs on the falling edge and queue the expected state.
  task automatic apply(input logic adv, input logic [W-1:0] ups);
    string tag;
    @(negedge clk_i);
    advance_i = adv;
    upset_i   = ups;
    if (frozen_left > 0) begin
      frozen_left--;
      tag = "R1";
    end else begin
      if (ups != '0) begin
        tag = (model != '0 && (model & ~ups) == '0 && !adv) ? "R10" : "R9";
      end else if (!adv) begin
        tag = "R5";
      end else if ($countones(model) >= 2) begin
        tag = "R8";
      end else if (model == '0) begin
        tag = "R2";
      end else if (model[W-1]) begin
        tag = "R4";
      end else begin
        tag = "R3";
      end
      if (adv) model = {model[W-2:0], (model == '0)};
      model = model ^ ups;
    end
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  task automatic release_reset();
    @(negedge clk_i);
    rst_ni    = 1'b1;
    advance_i = 1'b1;
    upset_i   = '0;
    model     = '0;
    exp_q.push_back('0);
    tag_q.push_back("R1");
    frozen_left = 1;
  endtask

  initial begin
    #150000;
    miscompares++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    vectors = 0;
    miscompares = 0;
    frozen_left = 0;
    model = '0;
    advance_i = 1'b1;
    upset_i = '0;
    rst_ni = 1'b0;

    // R1: held in home during reset even with advance high.
    repeat (3) begin
      @(negedge clk_i);
      compare('0, "R1");
    end

    release_reset();
    apply(1'b1, '0);                       // second frozen edge (R1)
    for (int i = 0; i < 9; i++) apply(1'b1, '0);   // R2, R3, R4 laps
    for (int i = 0; i < 3; i++) apply(1'b0, '0);   // R5 hold
    apply(1'b1, '0);

    // R9/R8: create multi-hot patterns and let them drain.
    apply(1'b1, 3'b111);
    for (int i = 0; i < 4; i++) apply(1'b1, '0);
    apply(1'b0, 3'b101);
    for (int i = 0; i < 4; i++) apply(1'b1, '0);
    apply(1'b0, 3'b011);
    for (int i = 0; i < 3; i++) apply(1'b0, '0);
    for (int i = 0; i < 4; i++) apply(1'b1, '0);

    // R10: clear the only set bit, then resume from home.
    while (model != 3'b010) apply(1'b1, '0);
    apply(1'b0, 3'b010);
    for (int i = 0; i < 5; i++) apply(1'b1, '0);

    // R1: asynchronous clear between edges.
    while (model == '0) apply(1'b1, '0);
    @(negedge clk_i);
    advance_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    compare('0, "R1");
    @(negedge clk_i);
    release_reset();
    apply(1'b1, '0);
    for (int i = 0; i < 5; i++) apply(1'b1, '0);

    @(negedge clk_i);
    advance_i = 1'b0;
    repeat (2) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule